// File: doc/BRIEF.md
# General Register File with Sub-Word Access

This block stores the eight 32-bit working registers of a small processor core together with its 32-bit instruction pointer. Any register can be read or written as a whole word or through its low 16 bits. The first four registers can also be reached one byte at a time, through the low byte or the second byte of that low half. Two read ports and one write port operate in parallel. Each port carries a register index and a two-bit size code.

A narrow write merges its field into the stored word and leaves every other bit of that word as it was. A narrow read returns the chosen field zero-extended to 32 bits. A byte access to any of the upper four registers is refused. The refused write does not happen, and an illegal flag tells the decoder about it. Reads are combinational from the stored state, so a read in the same cycle as a write to the same register returns the old contents. The instruction pointer can be loaded with a new address or stepped forward by a fixed amount.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight registers to zero and sets `ip_value` to the parameter `IP_RESET`.
- R2: A write with size code 00 replaces all 32 bits of the indexed register, and a read with size code 00 returns all 32 bits.
- R3: A write with size code 01 replaces bits 15:0 of the indexed register and keeps bits 31:16.
- R4: A write with size code 10 to index 0..3 replaces bits 7:0 and keeps bits 31:8.
- R5: A write with size code 11 to index 0..3 replaces bits 15:8 with write data bits 7:0 and keeps bits 31:16 and 7:0.
- R6: A read with size code 01 returns bits 15:0, code 10 returns bits 7:0, and code 11 returns bits 15:8 in result bits 7:0. All higher result bits are zero.
- R7: A write with size code 10 or 11 to index 4..7 raises `wr_illegal` in that cycle and leaves the register unchanged.
- R8: A read with size code 10 or 11 at index 4..7 raises that port's illegal flag and returns zero.
- R9: A read of a register in the same cycle as a write to it returns the value held before the write.
- R10: The two read ports select their register and size independently of each other.
- R11: When `ip_load` is high, `ip_value` takes `ip_load_val` after the edge, whatever `ip_inc` is.
- R12: When `ip_inc` is high and `ip_load` is low, `ip_value` grows by `IP_STEP` after the edge. With both low it holds its value.
- R13: With `wr_en` low, no register changes, whatever the write index, size and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code (00 word, 01 low half, 10 low byte, 11 high byte) |
| wr_data | input | 32 | Write data, field taken from the low bits |
| wr_illegal | output | 1 | Write request refused (byte access to index 4..7) |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 byte access to index 4..7 |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 byte access to index 4..7 |
| ip_load | input | 1 | Load instruction pointer |
| ip_load_val | input | 32 | Address to load |
| ip_inc | input | 1 | Step instruction pointer |
| ip_value | output | 32 | Current instruction pointer |

## Verification
The bench builds the block with `IP_RESET` set to 0x100 and `IP_STEP` set to 2 rather than the defaults. A wrong reset address or a hard-wired step size therefore shows up at once. The register count stays at eight with a byte-capable group of four, so the refused-access boundary between index 3 and index 4 is reached by both the directed and the random stimulus.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int GPR_W  = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BLO  = 2'b10,
    SZ_BHI  = 2'b11
  } gpr_size_e;

  // byte-wide codes are only allowed on the byte-capable group
  function automatic logic gpr_access_ok(int unsigned idx, int unsigned byte_regs,
                                         gpr_size_e sz);
    return !(sz[1] && (idx >= byte_regs));
  endfunction

  // zero-extended field selected by the size code
  function automatic logic [GPR_W-1:0] gpr_extract(logic [GPR_W-1:0] w, gpr_size_e sz);
    case (sz)
      SZ_WORD: return w;
      SZ_HALF: return {{(GPR_W-HALF_W){1'b0}}, w[HALF_W-1:0]};
      SZ_BLO:  return {{(GPR_W-BYTE_W){1'b0}}, w[BYTE_W-1:0]};
      default: return {{(GPR_W-BYTE_W){1'b0}}, w[HALF_W-1:BYTE_W]};
    endcase
  endfunction

  // merge the low bits of nw into the field of old chosen by the size code
  function automatic logic [GPR_W-1:0] gpr_merge(logic [GPR_W-1:0] old,
                                                 logic [GPR_W-1:0] nw, gpr_size_e sz);
    case (sz)
      SZ_WORD: return nw;
      SZ_HALF: return {old[GPR_W-1:HALF_W], nw[HALF_W-1:0]};
      SZ_BLO:  return {old[GPR_W-1:BYTE_W], nw[BYTE_W-1:0]};
      default: return {old[GPR_W-1:HALF_W], nw[BYTE_W-1:0], old[BYTE_W-1:0]};
    endcase
  endfunction

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][GPR_W-1:0] regs,
  input  logic [IDX_W-1:0]               idx,
  input  logic [1:0]                     size,
  output logic [GPR_W-1:0]               data,
  output logic                           illegal
);

  gpr_size_e sz;
  logic      ok;

  assign sz      = gpr_size_e'(size);
  assign ok      = gpr_access_ok(int'(idx), BYTE_REGS, sz);
  assign illegal = !ok;
  assign data    = ok ? gpr_extract(regs[idx], sz) : '0;

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [GPR_W-1:0]  wr_data,
  input  logic [GPR_W-1:0]  old_word,
  output logic              commit,
  output logic              illegal,
  output logic [GPR_W-1:0]  merged
);

  gpr_size_e sz;
  logic      ok;

  assign sz      = gpr_size_e'(wr_size);
  assign ok      = gpr_access_ok(int'(wr_idx), BYTE_REGS, sz);
  assign illegal = wr_en && !ok;
  assign commit  = wr_en && ok;
  assign merged  = gpr_merge(old_word, wr_data, sz);

endmodule

// File: rtl/gpr_ip_reg.sv
module gpr_ip_reg #(
  parameter int          IP_W     = 32,
  parameter logic [31:0] IP_RESET = 32'h0000_1000,
  parameter int          IP_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [IP_W-1:0] load_val,
  input  logic            inc,
  output logic [IP_W-1:0] ip
);

  localparam logic [IP_W-1:0] STEP_V  = IP_W'(IP_STEP);
  localparam logic [IP_W-1:0] START_V = IP_W'(IP_RESET);

  logic [IP_W-1:0] ip_next;

  always_comb begin
    if (load)     ip_next = load_val;
    else if (inc) ip_next = ip + STEP_V;
    else          ip_next = ip;
  end

  always_ff @(posedge clk) begin
    if (rst) ip <= START_V;
    else     ip <= ip_next;
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int          NUM_REGS  = 8,
  parameter int          BYTE_REGS = 4,
  parameter int          IP_W      = 32,
  parameter logic [31:0] IP_RESET  = 32'h0000_1000,
  parameter int          IP_STEP   = 4,
  localparam int         IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [GPR_W-1:0]  wr_data,
  output logic              wr_illegal,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [GPR_W-1:0]  rd0_data,
  output logic              rd0_illegal,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [GPR_W-1:0]  rd1_data,
  output logic              rd1_illegal,
  input  logic              ip_load,
  input  logic [IP_W-1:0]   ip_load_val,
  input  logic              ip_inc,
  output logic [IP_W-1:0]   ip_value
);

  logic [NUM_REGS-1:0][GPR_W-1:0] regs;
  logic                           wr_commit;
  logic [GPR_W-1:0]               wr_merged;

  gpr_write_merge #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wmerge (
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .old_word (regs[wr_idx]),
    .commit   (wr_commit),
    .illegal  (wr_illegal),
    .merged   (wr_merged)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [GPR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                         q <= '0;
      else if (wr_commit && (wr_idx == IDX_W'(g)))     q <= wr_merged;
    end
    assign regs[g] = q;
  end

  gpr_read_port #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_rd0 (
    .regs    (regs),
    .idx     (rd0_idx),
    .size    (rd0_size),
    .data    (rd0_data),
    .illegal (rd0_illegal)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_rd1 (
    .regs    (regs),
    .idx     (rd1_idx),
    .size    (rd1_size),
    .data    (rd1_data),
    .illegal (rd1_illegal)
  );

  gpr_ip_reg #(.IP_W(IP_W), .IP_RESET(IP_RESET), .IP_STEP(IP_STEP)) u_ip (
    .clk      (clk),
    .rst      (rst),
    .load     (ip_load),
    .load_val (ip_load_val),
    .inc      (ip_inc),
    .ip       (ip_value)
  );

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int          IDX_W    = 3,
  parameter int          IP_W     = 32,
  parameter logic [31:0] IP_RESET = 32'h0000_1000,
  parameter int          IP_STEP  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_size,
  input logic [31:0]      wr_data,
  input logic             wr_illegal,
  input logic             wr_commit,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [1:0]       rd0_size,
  input logic [31:0]      rd0_data,
  input logic             rd0_illegal,
  input logic [IDX_W-1:0] rd1_idx,
  input logic [1:0]       rd1_size,
  input logic [31:0]      rd1_data,
  input logic             rd1_illegal,
  input logic             ip_load,
  input logic [IP_W-1:0]  ip_load_val,
  input logic             ip_inc,
  input logic [IP_W-1:0]  ip_value
);

  // R1
  reset_ip_chk: assert property (@(posedge clk) rst |=> ip_value == IP_W'(IP_RESET));

  // R7
  illegal_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |-> !wr_commit);

  // R13
  idle_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_commit);

  // R8
  rd0_illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> rd0_data == 32'd0);

  // R8
  rd1_illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd1_illegal |-> rd1_data == 32'd0);

  // R6
  rd0_narrow_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_size != 2'b00) |-> rd0_data[31:16] == 16'd0);

  // R6
  rd1_byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
    rd1_size[1] |-> rd1_data[31:8] == 24'd0);

  // R3
  half_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == 2'b01) |=>
      (!(rd0_idx == $past(wr_idx) && rd0_size == 2'b00) ||
       rd0_data[15:0] == $past(wr_data[15:0])));

  // R11
  ip_load_chk: assert property (@(posedge clk) disable iff (rst)
    ip_load |=> ip_value == $past(ip_load_val));

  // R12
  ip_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!ip_load && ip_inc) |=> ip_value == $past(ip_value) + IP_W'(IP_STEP));

  // R12
  ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ip_load && !ip_inc) |=> $stable(ip_value));

endmodule

bind gpr_file gpr_file_chk #(
  .IDX_W    (IDX_W),
  .IP_W     (IP_W),
  .IP_RESET (IP_RESET),
  .IP_STEP  (IP_STEP)
) u_chk (.*);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] B_IP_RESET = 32'h0000_0100;
  localparam int          B_IP_STEP  = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic [31:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;
  logic        ip_load, ip_inc;
  logic [31:0] ip_load_val, ip_value;

  gpr_file #(.IP_RESET(B_IP_RESET), .IP_STEP(B_IP_STEP)) u_gpr_file (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .ip_load(ip_load), .ip_load_val(ip_load_val), .ip_inc(ip_inc), .ip_value(ip_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string ip_tag = "R1";

  logic [31:0] m_regs [8];
  logic [31:0] m_ip;

  function automatic bit refused(int idx, int sz);
    return (sz >= 2) && (idx >= 4);
  endfunction

  function automatic logic [31:0] ref_read(int idx, int sz);
    int          width;
    int          shift;
    logic [31:0] mask;
    if (refused(idx, sz)) return 32'd0;
    width = (sz == 0) ? 32 : ((sz == 1) ? 16 : 8);
    shift = (sz == 3) ? 8 : 0;
    mask  = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (m_regs[idx] >> shift) & mask;
  endfunction

  task automatic ref_write(int idx, int sz, logic [31:0] d);
    int          width;
    int          shift;
    logic [31:0] mask;
    width = (sz == 0) ? 32 : ((sz == 1) ? 16 : 8);
    shift = (sz == 3) ? 8 : 0;
    mask  = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    m_regs[idx] = (m_regs[idx] & ~(mask << shift)) | ((d & mask) << shift);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // one cycle: drive at the falling edge, compare, then advance the model at the rising edge
  task automatic cyc(bit we, int widx, int wsz, logic [31:0] wd,
                     int r0i, int r0s, int r1i, int r1s,
                     bit ipl, logic [31:0] iplv, bit ipi, string rtag);
    @(negedge clk);
    wr_en = we; wr_idx = 3'(widx); wr_size = 2'(wsz); wr_data = wd;
    rd0_idx = 3'(r0i); rd0_size = 2'(r0s); rd1_idx = 3'(r1i); rd1_size = 2'(r1s);
    ip_load = ipl; ip_load_val = iplv; ip_inc = ipi;
    #1;
    check(refused(r0i, r0s) ? "R8" : rtag, rd0_data, ref_read(r0i, r0s));
    check(refused(r1i, r1s) ? "R8" : rtag, rd1_data, ref_read(r1i, r1s));
    check("R8", {31'd0, rd0_illegal}, {31'd0, refused(r0i, r0s)});
    check("R8", {31'd0, rd1_illegal}, {31'd0, refused(r1i, r1s)});
    check("R7", {31'd0, wr_illegal}, {31'd0, we && refused(widx, wsz)});
    check(ip_tag, ip_value, m_ip);
    @(posedge clk);
    if (we && !refused(widx, wsz)) ref_write(widx, wsz, wd);
    if (ipl)      begin m_ip = iplv;                       ip_tag = "R11"; end
    else if (ipi) begin m_ip = m_ip + 32'(B_IP_STEP);      ip_tag = "R12"; end
    else          ip_tag = "R12";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
    rd0_idx = '0; rd0_size = '0; rd1_idx = '0; rd1_size = '0;
    ip_load = 1'b0; ip_load_val = '0; ip_inc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_regs[i] = 32'd0;
    m_ip = B_IP_RESET;

    // R1: everything cleared, pointer at its start address
    for (int i = 0; i < 8; i += 2) cyc(0, 0, 0, 0, i, 0, i + 1, 0, 0, 0, 0, "R1");

    // R2: full-word write and readback
    cyc(1, 0, 0, 32'h1122_3344, 0, 0, 1, 0, 0, 0, 0, "R2");
    cyc(1, 1, 0, 32'hCAFE_F00D, 0, 0, 1, 0, 0, 0, 0, "R2");
    cyc(1, 5, 0, 32'h8765_4321, 0, 0, 1, 0, 0, 0, 0, "R2");
    cyc(1, 3, 0, 32'hDEAD_BEEF, 5, 0, 1, 0, 0, 0, 0, "R2");

    // R3: half write keeps the upper half
    cyc(1, 0, 1, 32'hFFFF_ABCD, 3, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 6, 1, 32'h0000_9876, 0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 6, 0, 0, 0, 0, 0, 0, "R3");

    // R4: low-byte write keeps bits 31:8
    cyc(1, 3, 2, 32'h1234_56EE, 3, 0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 3, 0, 3, 2, 0, 0, 0, "R4");

    // R5: high-byte write takes data bits 7:0 into bits 15:8
    cyc(1, 1, 3, 32'hFFFF_FF5A, 1, 0, 1, 3, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 1, 3, 0, 0, 0, "R5");

    // R6: narrow reads are zero-extended
    cyc(0, 0, 0, 0, 1, 1, 1, 2, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 3, 3, 5, 1, 0, 0, 0, "R6");

    // R7: refused byte writes leave the register intact
    cyc(1, 5, 2, 32'h0000_00AA, 5, 0, 4, 0, 0, 0, 0, "R7");
    cyc(1, 7, 3, 32'h0000_00BB, 5, 0, 7, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 5, 0, 7, 0, 0, 0, 0, "R7");

    // R8: refused byte reads return zero with the flag
    cyc(0, 0, 0, 0, 5, 2, 6, 3, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 4, 3, 3, 3, 0, 0, 0, "R8");

    // R9: same-cycle read returns the old value
    cyc(1, 2, 0, 32'hAAAA_5555, 2, 0, 2, 1, 0, 0, 0, "R9");
    cyc(1, 2, 2, 32'h0000_0011, 2, 0, 2, 2, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 2, 0, 2, 2, 0, 0, 0, "R9");

    // R10: independent read ports
    cyc(0, 0, 0, 0, 0, 3, 6, 1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 6, 0, 0, 2, 0, 0, 0, "R10");

    // R11: load wins over increment
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 32'h0000_4000, 1, "R11");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, 0, "R11");

    // R12: increments wrap and hold
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R12");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R12");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R12");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R12");

    // R13: disabled writes change nothing
    cyc(0, 2, 0, 32'h0BAD_0BAD, 2, 0, 4, 0, 0, 0, 0, "R13");
    cyc(0, 4, 1, 32'h0BAD_0BAD, 2, 0, 4, 0, 0, 0, 0, "R13");
    cyc(0, 0, 0, 0, 2, 0, 4, 0, 0, 0, 0, "R13");

    // mixed traffic against the reference model
    for (int k = 0; k < 1500; k++) begin
      int          r0s;
      logic [31:0] rv;
      r0s = int'($urandom_range(0, 3));
      rv  = $urandom;
      cyc(bit'(rv[0] | rv[1]), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), $urandom,
          int'($urandom_range(0, 7)), r0s, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
          bit'(rv[7:4] == 4'h0), $urandom, bit'(rv[2]),
          (r0s == 0) ? "R2" : "R6");
    end

    done = 1'b1;
    finish_run();
  end

endmodule